// File: doc/BRIEF.md
# Priority Interrupt Controller

This block collects eight interrupt request lines, latches each new request, hides the lines that software has disabled, and signals the CPU when a request outranks every level that is already being serviced. The CPU answers with a two-pulse acknowledge. On the first pulse the controller commits the winning level to its in-service set. During the second pulse it presents an 8-bit vector formed from a programmable base and the level number.

Software reaches the block through a byte-wide port pair selected by one address bit. It has separate active-low read and write strobes. Writing a start word to the even port opens a three-word setup sequence on the odd port. Those words set the vector base, carry a cascade word that is consumed and not stored, and choose between explicit and automatic end-of-interrupt. After setup, odd-port writes load the line mask. Even-port writes either end service of a level or choose which status byte an even-port read returns.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, int_out is 0, an odd-port read returns mask 0xFF, and an even-port read returns the request byte, which is 0x00.
- R2: An even-port write with din[4]=1 clears the mask to 0x00, selects request-byte reads and starts setup. The next three odd-port writes, in order, are the vector base, a cascade word that is discarded, and the mode word. None of the three changes the mask.
- R3: While the second acknowledge pulse is low, dout equals the base with its bits 2:0 replaced by the committed level number.
- R4: An odd-port write outside setup loads the mask, and an odd-port read returns it. A mask bit of 1 keeps that line from raising int_out, while its request stays latched.
- R5: A rising edge on irq_in[n] sets request bit n. The bit clears when the line is low at a clock edge, or when level n is committed by an acknowledge.
- R6: Line 0 has the highest priority and line 7 the lowest. int_out is 1 exactly when an unmasked pending line has a smaller index than every in-service level.
- R7: The falling edge of the first acknowledge pulse sets the in-service bit of the winning line and clears its request bit. At most one in-service bit is set per cycle.
- R8: An even-port write of 0x60+n clears in-service bit n and no other bit.
- R9: An even-port write of 0x20 clears the lowest-index in-service bit.
- R10: Even-port writes of 0x0A and 0x0B make later even-port reads return the request byte or the in-service byte. The choice persists until it is changed.
- R11: When mode word bit 1 is 1, the committed in-service bit clears as the second acknowledge pulse ends. When bit 1 is 0, the bit stays set until an end-of-interrupt write.
- R12: If no line qualifies at the first acknowledge pulse, the vector is base+7 and the in-service byte is unchanged, even when line 7 is masked.
- R13: An end-of-interrupt write in the same cycle as the first acknowledge edge takes effect together with the new in-service bit. The write acts on the in-service byte as it was before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a0 | input | 1 | Port select: 0 even, 1 odd |
| wr_n | input | 1 | Active-low write strobe, one write per low cycle |
| rd_n | input | 1 | Active-low read strobe |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or interrupt vector |
| irq_in | input | 8 | Interrupt request lines |
| int_out | output | 1 | Interrupt request to the CPU |
| inta_n | input | 1 | Active-low acknowledge pulses |

## Verification
The in-service byte has two writers that can act on the same clock edge: the first acknowledge edge sets a bit, and an end-of-interrupt write clears one. The bench drops inta_n and issues a non-specific end-of-interrupt in the same cycle, while level 3 is in service and level 1 is being committed. It then reads the in-service byte and expects only level 1 to remain. A design that lets one writer mask the other leaves either both bits set or neither.

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a0,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  input  logic [DATA_W-1:0] irq_in,
  output logic              int_out,
  input  logic              inta_n
);
  localparam int LVL_W = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  typedef enum logic [1:0] {ACK_IDLE, ACK_GAP, ACK_VEC} ack_t;

  logic [DATA_W-1:0]       irr, isr, imr, irq_q;
  logic [DATA_W-1:LVL_W]   base;
  logic [1:0]              init_step;
  logic                    aeoi, rd_isr, inta_q, spur;
  logic [LVL_W-1:0]        lvl;
  ack_t                    ack_st;

  function automatic logic [LVL_W-1:0] enc(input logic [DATA_W-1:0] v);
    enc = '0;
    for (int i = DATA_W-1; i >= 0; i--)
      if (v[i]) enc = LVL_W'(i);
  endfunction

  wire wr_even = !wr_n && !a0;
  wire wr_odd  = !wr_n &&  a0;
  wire start   = wr_even &&  din[4];
  wire sel_wr  = wr_even && !din[4] &&  din[3];
  wire eoi_wr  = wr_even && !din[4] && !din[3];

  wire [DATA_W-1:0] pending = irr & ~imr;
  wire [DATA_W-1:0] isr_low = isr & (~isr + ONE);
  wire [DATA_W-1:0] elig    = pending & (isr_low - ONE);
  wire [DATA_W-1:0] win     = elig & (~elig + ONE);
  wire              any     = |elig;

  wire ack_fall = !inta_n &&  inta_q;
  wire ack_rise =  inta_n && !inta_q;
  wire take     = ack_fall && (ack_st == ACK_IDLE);

  logic [DATA_W-1:0] isr_set, isr_clr;
  logic vec_phase;

  always_comb begin
    isr_set = (take && any) ? win : '0;
    isr_clr = '0;
    if (eoi_wr && din[7:5] == 3'b001) isr_clr = isr_low;
    if (eoi_wr && din[7:5] == 3'b011) isr_clr = ONE << din[LVL_W-1:0];
    if (ack_rise && ack_st == ACK_VEC && aeoi && !spur) isr_clr = isr_clr | (ONE << lvl);
  end

  assign int_out   = any;
  assign vec_phase = (ack_st == ACK_VEC) && !inta_n;

  always_comb begin
    if (vec_phase)  dout = {base, lvl};
    else if (!rd_n) dout = a0 ? imr : (rd_isr ? isr : irr);
    else            dout = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q     <= '0;
      inta_q    <= 1'b1;
      irr       <= '0;
      isr       <= '0;
      imr       <= '1;
      base      <= '0;
      init_step <= '0;
      aeoi      <= 1'b0;
      rd_isr    <= 1'b0;
      lvl       <= '0;
      spur      <= 1'b0;
      ack_st    <= ACK_IDLE;
    end else begin
      irq_q  <= irq_in;
      inta_q <= inta_n;
      irr    <= irq_in & (irr | ~irq_q) & ~isr_set;

      if (start) isr <= '0;
      else       isr <= (isr | isr_set) & ~isr_clr;

      if (start) begin
        init_step <= 2'd1;
        imr       <= '0;
        rd_isr    <= 1'b0;
        aeoi      <= 1'b0;
      end else if (wr_odd) begin
        case (init_step)
          2'd1: begin base <= din[DATA_W-1:LVL_W]; init_step <= 2'd2; end
          2'd2: init_step <= 2'd3;
          2'd3: begin aeoi <= din[1]; init_step <= 2'd0; end
          default: imr <= din;
        endcase
      end else if (sel_wr && din[1]) begin
        rd_isr <= din[0];
      end

      case (ack_st)
        ACK_IDLE: if (ack_fall) begin
          lvl    <= any ? enc(win) : '1;
          spur   <= !any;
          ack_st <= ACK_GAP;
        end
        ACK_GAP:  if (ack_fall) ack_st <= ACK_VEC;
        default:  if (ack_rise) ack_st <= ACK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
`timescale 1ns/1ps
module prio_irq_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int LVL_W  = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [DATA_W-1:0]       irq_in,
  input logic                    int_out,
  input logic [DATA_W-1:0]       dout,
  input logic [DATA_W-1:0]       irr,
  input logic [DATA_W-1:0]       isr,
  input logic [DATA_W-1:0]       imr,
  input logic [DATA_W-1:LVL_W]   base,
  input logic                    vec_phase
);
  // R1
  reset_mask_chk: assert property (@(posedge clk) !rst_n |=> imr == '1);

  // R4
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (irr & ~imr) != '0);

  // R6
  top_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    isr[0] |-> !int_out);

  // R7
  one_isr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isr & ~$past(isr)));

  // R5
  irr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irr & ~$past(irq_in)) == '0);

  // R3
  vec_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_phase |-> dout[DATA_W-1:LVL_W] == base);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .int_out(int_out), .dout(dout),
  .irr(irr), .isr(isr), .imr(imr), .base(base), .vec_phase(vec_phase)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a0 = 1'b0, wr_n = 1'b1, rd_n = 1'b1, inta_n = 1'b1;
  logic [7:0] din = 8'h00, irq_in = 8'h00;
  logic [7:0] dout;
  logic int_out;
  int checks = 0, fails = 0;
  logic [7:0] v;

  always #10 clk = ~clk;

  prio_irq_ctrl u_dut (.clk(clk), .rst_n(rst_n), .a0(a0), .wr_n(wr_n), .rd_n(rd_n),
    .din(din), .dout(dout), .irq_in(irq_in), .int_out(int_out), .inta_n(inta_n));

  // {pattern, mask, expected int_out, expected vector}; base 0x20, explicit EOI
  localparam logic [31:0] TAB [6] = '{
    32'h01_00_01_20, 32'h80_00_01_27, 32'h18_00_01_23,
    32'h18_08_01_24, 32'hF0_F0_00_27, 32'h06_02_01_22 };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic odd, input logic [7:0] d);
    @(negedge clk); a0 = odd; din = d; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
  endtask

  task automatic rd(input logic odd, output logic [7:0] d);
    @(negedge clk); a0 = odd; rd_n = 1'b0;
    #2 d = dout;
    rd_n = 1'b1;
  endtask

  task automatic ack(output logic [7:0] vec);
    @(negedge clk); inta_n = 1'b0;
    @(negedge clk); inta_n = 1'b1;
    @(negedge clk); inta_n = 1'b0;
    @(negedge clk); vec = dout; inta_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 int_out", {7'b0, int_out}, 8'h00);
    rd(1'b1, v); chk("R1 mask", v, 8'hFF);
    rd(1'b0, v); chk("R1 irr", v, 8'h00);

    // R2 setup sequence
    wr(1'b0, 8'h11); wr(1'b1, 8'h20);
    rd(1'b1, v); chk("R2 mask mid-setup", v, 8'h00);
    wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    rd(1'b1, v); chk("R2 mask after setup", v, 8'h00);

    for (int k = 0; k < 6; k++) begin
      logic [7:0] pat, msk, ei, ev, eisr;
      {pat, msk, ei, ev} = TAB[k];
      eisr = ei[0] ? (8'h01 << (ev - 8'h20)) : 8'h00;
      wr(1'b1, msk);
      irq_in = pat; settle();
      chk("R6 table int_out", {7'b0, int_out}, ei);
      ack(v); chk("R3 table vector", v, ev);
      wr(1'b0, 8'h0B); rd(1'b0, v); chk("R7 table isr", v, eisr);
      wr(1'b0, 8'h20); rd(1'b0, v); chk("R9 table eoi", v, 8'h00);
      irq_in = 8'h00; wr(1'b1, 8'h00); wr(1'b0, 8'h0A); settle();
    end

    // R10 read selection
    irq_in = 8'h08; settle();
    rd(1'b0, v); chk("R10 irr read", v, 8'h08);
    wr(1'b0, 8'h0B); rd(1'b0, v); chk("R10 isr read", v, 8'h00);
    ack(v); chk("R3 vector lvl3", v, 8'h23);
    rd(1'b0, v); chk("R10 isr persists", v, 8'h08);
    wr(1'b0, 8'h0A); rd(1'b0, v); chk("R7 irr cleared by ack", v, 8'h00);

    // R6 nesting
    irq_in = 8'h28; settle();
    chk("R6 lower blocked", {7'b0, int_out}, 8'h00);
    rd(1'b0, v); chk("R5 irr lvl5 latched", v, 8'h20);
    irq_in = 8'h2A; settle();
    chk("R6 higher preempts", {7'b0, int_out}, 8'h01);

    // R13 EOI write on the first acknowledge edge
    @(negedge clk); inta_n = 1'b0; a0 = 1'b0; din = 8'h20; wr_n = 1'b0;
    @(negedge clk); inta_n = 1'b1; wr_n = 1'b1;
    @(negedge clk); inta_n = 1'b0;
    @(negedge clk); v = dout; inta_n = 1'b1;
    @(negedge clk);
    chk("R13 vector", v, 8'h21);
    wr(1'b0, 8'h0B); rd(1'b0, v); chk("R13 isr", v, 8'h02);

    // R8 specific EOI
    chk("R6 lvl5 blocked by lvl1", {7'b0, int_out}, 8'h00);
    wr(1'b0, 8'h61); rd(1'b0, v); chk("R8 clear lvl1", v, 8'h00);
    chk("R6 lvl5 now raises", {7'b0, int_out}, 8'h01);
    ack(v); chk("R3 vector lvl5", v, 8'h25);
    rd(1'b0, v); chk("R11 explicit eoi retains", v, 8'h20);
    wr(1'b0, 8'h63); rd(1'b0, v); chk("R8 other level untouched", v, 8'h20);
    wr(1'b0, 8'h65); rd(1'b0, v); chk("R8 clear lvl5", v, 8'h00);
    irq_in = 8'h00; wr(1'b0, 8'h0A); settle();

    // R4 mask
    wr(1'b1, 8'hFF); rd(1'b1, v); chk("R4 mask read", v, 8'hFF);
    irq_in = 8'h01; settle();
    chk("R4 masked no int", {7'b0, int_out}, 8'h00);
    rd(1'b0, v); chk("R4 masked still latched", v, 8'h01);
    wr(1'b1, 8'h00); @(negedge clk);
    chk("R4 unmask raises", {7'b0, int_out}, 8'h01);
    ack(v); chk("R3 vector lvl0", v, 8'h20);
    wr(1'b0, 8'h20); irq_in = 8'h00; settle();

    // R11 automatic end of interrupt, new base
    wr(1'b0, 8'h11); wr(1'b1, 8'h08); wr(1'b1, 8'h04); wr(1'b1, 8'h03);
    rd(1'b1, v); chk("R2 mask after second setup", v, 8'h00);
    irq_in = 8'h04; settle();
    ack(v); chk("R3 vector base 08", v, 8'h0A);
    wr(1'b0, 8'h0B); rd(1'b0, v); chk("R11 auto eoi clears", v, 8'h00);
    irq_in = 8'h00;

    // R12 spurious level with line 7 masked
    wr(1'b1, 8'h80);
    irq_in = 8'h10; settle();
    chk("R12 int before drop", {7'b0, int_out}, 8'h01);
    irq_in = 8'h00; settle();
    chk("R5 drop clears request", {7'b0, int_out}, 8'h00);
    ack(v); chk("R12 spurious vector", v, 8'h0F);
    rd(1'b0, v); chk("R12 isr unchanged", v, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule